// File: doc/BRIEF.md
# Four-Mode Eight-Bit Addressable Latch

This block keeps eight single-bit values behind a 3-bit address. A one-bit data input, an active-low enable and an active-low functional clear steer it. The two control inputs together pick one of four modes. The block can write one addressed bit, hold every bit, clear the whole bank, or act as a one-of-eight decoder in which only the addressed output can be high. All eight stored bits drive a parallel output bus at all times.

Every control is sampled on the rising clock edge, and the outputs come straight from registers. The block uses no transparent latches. Because the address should only move while the bank is holding, a guard output raises a one-cycle flag when the address differs between two consecutive samples that both had the enable asserted. A synchronous active-low system reset zeroes the bank and the flag, separately from the functional clear.

Top module: `addr_latch8`

## Requirements
- R1: The address value k selects storage bit k, and bit k is driven on line k of `bits_q`. Bit 0 is the least significant line.
- R2: In write mode (`clr_n`=1, `wr_en_n`=0), the addressed bit takes `din` at the rising edge and the other seven bits keep their values.
- R3: In hold mode (`clr_n`=1, `wr_en_n`=1), all eight bits keep their values whatever `din` and `sel_addr` carry.
- R4: In clear mode (`clr_n`=0, `wr_en_n`=1), all eight bits become 0 at the edge, whatever `din` and `sel_addr` carry.
- R5: In decode mode (`clr_n`=0, `wr_en_n`=0), the addressed bit becomes `din` and every other bit becomes 0 at the edge.
- R6: `rst_n` low at a rising edge sets all bits and `addr_slip` to 0, overriding every other input.
- R7: `addr_slip` is 1 for exactly the cycle after an edge at which `wr_en_n` was 0, `wr_en_n` had also been 0 at the previous edge, and `sel_addr` differs from its value at that previous edge. Otherwise it is 0.
- R8: After decode mode ends in hold mode, the pattern decode mode produced stays on `bits_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| sel_addr | input | 3 | Bit address |
| din | input | 1 | Data bit |
| wr_en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low functional clear |
| bits_q | output | 8 | Stored bits, line k is bit k |
| addr_slip | output | 1 | One-cycle flag: address moved while enable stayed asserted |

## Verification
The bench targets four corner cases. First, it writes neighbouring addresses back to back and checks that the other bits are untouched. A decoder with an off-by-one error, or a write that zeroes the bank, would corrupt them. Second, it enters decode mode with `din` at 0 and at 1. A design that confused decode with write would leave stale ones, and one that confused it with clear would lose the data bit. Third, it holds right after decode, where a design that kept decoding would erase the pattern. Fourth, it drives the guard through consecutive enabled cycles with the same and with different addresses, with a hold between them, and through reset. A guard that ignored the previous enable state, or that never cleared on reset, would raise false flags.

// File: rtl/addr_latch_pkg.sv
// Shared types for the addressable latch: mode encoding and the mode
// selection function. Assumes active-low clear and enable inputs.
package addr_latch_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE  = 2'd0,
        MODE_HOLD   = 2'd1,
        MODE_CLEAR  = 2'd2,
        MODE_DECODE = 2'd3
    } latch_mode_e;

    // Map the two active-low controls onto a mode.
    function automatic latch_mode_e pick_mode(input logic clr_n, input logic en_n);
        latch_mode_e m;
        case ({clr_n, en_n})
            2'b10:   m = MODE_WRITE;
            2'b11:   m = MODE_HOLD;
            2'b01:   m = MODE_CLEAR;
            default: m = MODE_DECODE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/latch_ctrl_decode.sv
// Control decode: turns the clear/enable pair into a mode and expands the
// address into a one-hot select. Purely combinational.
module latch_ctrl_decode
    import addr_latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              clr_n,
    input  logic              wr_en_n,
    output latch_mode_e       mode,
    output logic [NBITS-1:0]  sel_oh
);

    // Mode selection from the control pair.
    always_comb mode = pick_mode(clr_n, wr_en_n);

    // One select line per storage bit.
    for (genvar k = 0; k < NBITS; k++) begin : g_sel
        assign sel_oh[k] = (sel_addr == ADDR_W'(k));
    end

    // R1: exactly one bit is addressed at any time.
    always_comb assert_onehot_select_R1: assert (!$isunknown(sel_addr) -> $countones(sel_oh) == 1);

endmodule

// File: rtl/latch_next_state.sv
// Next-state logic for the storage bank: one slice per bit, chosen by the
// mode. Assumes sel_oh is one-hot.
module latch_next_state
    import addr_latch_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  latch_mode_e       mode,
    input  logic [NBITS-1:0]  sel_oh,
    input  logic              din,
    input  logic [NBITS-1:0]  cur_bits,
    output logic [NBITS-1:0]  nxt_bits
);

    for (genvar k = 0; k < NBITS; k++) begin : g_bit
        // Per-bit next value for the current mode.
        always_comb begin
            case (mode)
                MODE_WRITE:  nxt_bits[k] = sel_oh[k] ? din : cur_bits[k];
                MODE_HOLD:   nxt_bits[k] = cur_bits[k];
                MODE_CLEAR:  nxt_bits[k] = 1'b0;
                MODE_DECODE: nxt_bits[k] = sel_oh[k] & din;
                default:     nxt_bits[k] = cur_bits[k];
            endcase
        end
    end

endmodule

// File: rtl/latch_addr_guard.sv
// Address guard: flags, one cycle later, an address change between two
// consecutive samples that both had the enable asserted.
module latch_addr_guard #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              wr_en_n,
    output logic              addr_slip
);

    logic [ADDR_W-1:0] prev_addr;
    logic              prev_active;

    // Remember the last sample and raise the flag on a moved address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr   <= '0;
            prev_active <= 1'b0;
            addr_slip   <= 1'b0;
        end else begin
            prev_addr   <= sel_addr;
            prev_active <= !wr_en_n;
            addr_slip   <= !wr_en_n && prev_active && (sel_addr != prev_addr);
        end
    end

    // R7: a flag implies the enable was asserted at the edge that set it.
    assert_slip_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_slip) |-> $past(!wr_en_n));

    // R7: a repeated address never raises the flag.
    assert_slip_same_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_active && !wr_en_n && sel_addr == prev_addr) |=> !addr_slip);

endmodule

// File: rtl/addr_latch8.sv
// Four-mode addressable latch bank: write, hold, clear and one-of-N decode,
// all sampled on the rising edge, with registered outputs and an address
// guard. Assumes a synchronous active-low system reset.
module addr_latch8
    import addr_latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              din,
    input  logic              wr_en_n,
    input  logic              clr_n,
    output logic [NBITS-1:0]  bits_q,
    output logic              addr_slip
);

    latch_mode_e      mode_w;
    logic [NBITS-1:0] sel_oh;
    logic [NBITS-1:0] nxt_bits;

    latch_ctrl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel_addr (sel_addr),
        .clr_n    (clr_n),
        .wr_en_n  (wr_en_n),
        .mode     (mode_w),
        .sel_oh   (sel_oh)
    );

    latch_next_state #(.NBITS(NBITS)) u_next (
        .mode     (mode_w),
        .sel_oh   (sel_oh),
        .din      (din),
        .cur_bits (bits_q),
        .nxt_bits (nxt_bits)
    );

    latch_addr_guard #(.ADDR_W(ADDR_W)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_addr  (sel_addr),
        .wr_en_n   (wr_en_n),
        .addr_slip (addr_slip)
    );

    // Storage bank register.
    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= nxt_bits;
    end

    assert_reset_zero_R6: assert property (@(posedge clk)
        !rst_n |=> (bits_q == '0 && !addr_slip));

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == MODE_HOLD) |=> $stable(bits_q));

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == MODE_CLEAR) |=> (bits_q == '0));

    assert_decode_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == MODE_DECODE) |=> ((bits_q & ~$past(sel_oh)) == '0));

    assert_write_others_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == MODE_WRITE) |=> ((bits_q & ~$past(sel_oh)) == ($past(bits_q) & ~$past(sel_oh))));

    assert_write_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == MODE_WRITE) |=> ((bits_q & $past(sel_oh)) == ($past(din) ? $past(sel_oh) : '0)));

endmodule

// File: tb/addr_latch8_bench.sv
module addr_latch8_bench;

    localparam int AW = 3;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] sel_addr = '0;
    logic          din = 1'b0;
    logic          wr_en_n = 1'b1;
    logic          clr_n = 1'b1;
    logic [NB-1:0] bits_q;
    logic          addr_slip;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [NB-1:0] m_bits = '0;
    logic [AW-1:0] m_prev_addr = '0;
    logic          m_prev_act = 1'b0;
    logic          m_slip = 1'b0;

    addr_latch8 #(.ADDR_W(AW)) u_addr_latch8 (
        .clk(clk), .rst_n(rst_n), .sel_addr(sel_addr), .din(din),
        .wr_en_n(wr_en_n), .clr_n(clr_n), .bits_q(bits_q), .addr_slip(addr_slip)
    );

    always #10 clk = ~clk;

    function automatic logic [NB-1:0] next_bits(logic [NB-1:0] cur, logic [AW-1:0] a,
                                                logic d, logic en_n, logic c_n, logic r_n);
        logic [NB-1:0] r;
        r = cur;
        if (!r_n) r = '0;
        else if (c_n && !en_n) r[a] = d;
        else if (!c_n && en_n) r = '0;
        else if (!c_n && !en_n) begin r = '0; r[a] = d; end
        return r;
    endfunction

    task automatic check(string tag, logic [NB-1:0] exp_b, logic exp_s);
        n_run++;
        if (bits_q !== exp_b) begin
            n_fail++;
            $display("FAIL %s bits_q actual %b expected %b", tag, bits_q, exp_b);
        end
        n_run++;
        if (addr_slip !== exp_s) begin
            n_fail++;
            $display("FAIL %s addr_slip actual %b expected %b", tag, addr_slip, exp_s);
        end
    endtask

    task automatic step(string tag, logic [AW-1:0] a, logic d, logic en_n, logic c_n, logic r_n);
        @(negedge clk);
        sel_addr = a; din = d; wr_en_n = en_n; clr_n = c_n; rst_n = r_n;
        @(posedge clk);
        m_bits = next_bits(m_bits, a, d, en_n, c_n, r_n);
        if (!r_n) begin
            m_slip = 1'b0; m_prev_act = 1'b0; m_prev_addr = '0;
        end else begin
            m_slip = !en_n && m_prev_act && (a != m_prev_addr);
            m_prev_act = !en_n;
            m_prev_addr = a;
        end
        #5;
        check(tag, m_bits, m_slip);
    endtask

    initial begin
        // R6: reset state
        step("R6", 3'd5, 1'b1, 1'b0, 1'b1, 1'b0);
        step("R6", 3'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        // R1/R2: walk every address, writes in hold between to avoid slips
        for (int k = 0; k < NB; k++) begin
            step("R1", AW'(k), k[0], 1'b0, 1'b1, 1'b1);
            step("R3", AW'(k), 1'b1, 1'b1, 1'b1, 1'b1);
        end
        // R2: overwrite bit 3 with 1 then 0, neighbours untouched
        step("R2", 3'd3, 1'b1, 1'b0, 1'b1, 1'b1);
        step("R2", 3'd3, 1'b0, 1'b0, 1'b1, 1'b1);
        // R3: hold with arbitrary data and address
        step("R3", 3'd7, 1'b0, 1'b1, 1'b1, 1'b1);
        step("R3", 3'd1, 1'b1, 1'b1, 1'b1, 1'b1);
        // R4: clear ignores data and address
        step("R4", 3'd6, 1'b1, 1'b1, 1'b0, 1'b1);
        // R5: decode with din 1 then din 0 (fresh address, prior hold)
        step("R2", 3'd2, 1'b1, 1'b0, 1'b1, 1'b1);
        step("R3", 3'd2, 1'b1, 1'b1, 1'b1, 1'b1);
        step("R5", 3'd4, 1'b1, 1'b0, 1'b0, 1'b1);
        // R8: decode pattern survives hold
        step("R8", 3'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        step("R8", 3'd6, 1'b1, 1'b1, 1'b1, 1'b1);
        step("R5", 3'd4, 1'b0, 1'b0, 1'b0, 1'b1);
        // R7: consecutive enabled cycles, same then different address
        step("R7", 3'd1, 1'b1, 1'b0, 1'b1, 1'b1);
        step("R7", 3'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        step("R7", 3'd2, 1'b1, 1'b0, 1'b1, 1'b1);
        step("R7", 3'd5, 1'b1, 1'b0, 1'b0, 1'b1);
        step("R7", 3'd5, 1'b1, 1'b1, 1'b1, 1'b1);
        step("R7", 3'd6, 1'b1, 1'b0, 1'b1, 1'b1);
        // R6: reset overrides write and clears flag state
        step("R7", 3'd0, 1'b1, 1'b0, 1'b1, 1'b1);
        step("R6", 3'd3, 1'b1, 1'b0, 1'b1, 1'b0);
        step("R7", 3'd4, 1'b1, 1'b0, 1'b1, 1'b1);
        // Random mix across all modes
        void'($urandom(32'h5A17));
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] ra;
            logic rd, re, rc, rr;
            ra = AW'($urandom_range(0, NB - 1));
            rd = 1'($urandom_range(0, 1));
            re = ($urandom_range(0, 2) == 0);
            rc = ($urandom_range(0, 4) != 0);
            rr = ($urandom_range(0, 40) != 0);
            step(!rr ? "R6" : (rc && !re) ? "R2" : (rc && re) ? "R3" :
                 (!rc && re) ? "R4" : "R5", ra, rd, re, rc, rr);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule